// File: doc/BRIEF.md
# Mesochronous Lane Phase Synchronizer

This block moves the parallel words of one receive lane from the lane's recovered parallel clock into a shared global clock. Both clocks run at exactly the same frequency, and the only difference between them is an unknown but fixed phase. Every write-clock cycle stores one word into a four-entry circular buffer. Every read-clock cycle takes one word out. Neither side has an enable or a flow-control signal.

At reset the write pointer is placed two entries ahead of the read pointer. This gives about one cycle of margin in either direction before the two pointers could collide. Because the clocks are frequency locked, the distance between the pointers never grows or shrinks, so the block has no full or empty indication.

Reset is applied asynchronously. Each clock domain releases it through its own two-flop synchronizer. The read output is held at zero until the write side has stored two words.

Top module: `meso_sync_fifo`

## Requirements
- R1: The word width is the parameter `W`, and the buffer holds exactly 4 entries. `data_o` carries the full `W`-bit word that was captured from `data_i`.
- R2: After reset release, `data_i` is captured on every rising edge of `wclk_i`. No input word is ever skipped.
- R3: After lock, a new word is presented on `data_o` on every rising edge of `rclk_i`. No word is ever presented twice.
- R4: The output sequence is the input sequence, in order, after a fixed latency. At each sample the distance between the newest captured word and the word on `data_o` is between 1 and 4 words, and it stays constant for the whole run.
- R5: While `rst_ni` is low, `data_o` is zero, and it goes to zero as soon as `rst_ni` falls, without waiting for a clock.
- R6: After reset release, `data_o` stays zero until the write side has stored two words. The first non-zero word appears no earlier than 2 and no later than 10 read cycles after `rst_ni` rises.
- R7: The write pointer starts two entries ahead of the read pointer. Transfer is correct for any read-clock phase offset from 0 up to one full clock period.
- R8: Each pointer is a 2-bit counter that advances by one on every cycle of its own clock and wraps modulo 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Lane parallel clock; writes into the buffer |
| rclk_i | input | 1 | Global clock, same frequency as `wclk_i`; reads from the buffer |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| data_i | input | W | Parallel word in the write domain |
| data_o | output | W | Word retimed into the read domain |

## Verification
A write and a read that touch the same entry can fall within one clock period when the phase offset moves the read edge close to the write edge. The bench creates this case by delaying the read clock relative to the write clock. It sweeps the delay through the whole period, including offsets near zero and near a full cycle. In each run it identifies the first non-zero output word in the input history. It then requires every later output to be exactly the next input word, with the latency gap held inside its bound, so that any torn, dropped or repeated word is reported.

// File: rtl/msf_pkg.sv
`timescale 1ns/1ps
package msf_pkg;
  localparam int DEPTH = 4;
  localparam int PTR_W = $clog2(DEPTH);
  typedef logic [PTR_W-1:0] ptr_t;
  localparam ptr_t RD_PTR_INIT = '0;
  localparam ptr_t WR_PTR_INIT = ptr_t'(DEPTH / 2);
  localparam int PRIME_CNT = DEPTH / 2;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/msf_rst_sync.sv
`timescale 1ns/1ps
module msf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/msf_wr_side.sv
`timescale 1ns/1ps
module msf_wr_side
  import msf_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [W-1:0]              data_i,
  output logic [DEPTH-1:0][W-1:0]   mem_o,
  output ptr_t                      ptr_o,
  output logic                      primed_o
);
  localparam int FILL_W = $clog2(PRIME_CNT + 1);

  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= WR_PTR_INIT;
      fill_q <= '0;
    end else begin
      ptr_o <= ptr_o + ptr_t'(1);
      if (fill_q != FILL_W'(PRIME_CNT)) fill_q <= fill_q + FILL_W'(1);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 mem_o[i] <= '0;
      else if (ptr_o == ptr_t'(i)) mem_o[i] <= data_i;
    end
  end

  assign primed_o = (fill_q == FILL_W'(PRIME_CNT));
endmodule

// File: rtl/msf_rd_side.sv
`timescale 1ns/1ps
module msf_rd_side
  import msf_pkg::*;
#(
  parameter int W = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [DEPTH-1:0][W-1:0]   mem_i,
  input  logic                      primed_i,
  output ptr_t                      ptr_o,
  output logic                      primed_o,
  output logic [W-1:0]              data_o
);
  logic [SYNC_STAGES-1:0] prime_sync_q;

  // mem_i is stable around the read edge: the entry is rewritten only 2 cycles later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prime_sync_q <= '0;
      ptr_o        <= RD_PTR_INIT;
      data_o       <= '0;
    end else begin
      prime_sync_q <= {prime_sync_q[SYNC_STAGES-2:0], primed_i};
      ptr_o        <= ptr_o + ptr_t'(1);
      data_o       <= prime_sync_q[SYNC_STAGES-1] ? mem_i[ptr_o] : '0;
    end
  end

  assign primed_o = prime_sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/meso_sync_fifo.sv
`timescale 1ns/1ps
module meso_sync_fifo
  import msf_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         wclk_i,
  input  logic         rclk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o
);
  logic                    wr_rst_n, rd_rst_n;
  logic [DEPTH-1:0][W-1:0] mem;
  ptr_t                    wr_ptr, rd_ptr;
  logic                    wr_primed, rd_primed;

  msf_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk_i (wclk_i), .rst_ni (rst_ni), .rst_no (wr_rst_n)
  );

  msf_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk_i (rclk_i), .rst_ni (rst_ni), .rst_no (rd_rst_n)
  );

  msf_wr_side #(.W(W)) u_wr (
    .clk_i    (wclk_i),
    .rst_ni   (wr_rst_n),
    .data_i   (data_i),
    .mem_o    (mem),
    .ptr_o    (wr_ptr),
    .primed_o (wr_primed)
  );

  msf_rd_side #(.W(W)) u_rd (
    .clk_i    (rclk_i),
    .rst_ni   (rd_rst_n),
    .mem_i    (mem),
    .primed_i (wr_primed),
    .ptr_o    (rd_ptr),
    .primed_o (rd_primed),
    .data_o   (data_o)
  );
endmodule

// File: rtl/msf_checker.sv
`timescale 1ns/1ps
module msf_checker
  import msf_pkg::*;
#(
  parameter int W = 10
) (
  input logic         wclk_i,
  input logic         rclk_i,
  input logic         wr_rst_n,
  input logic         rd_rst_n,
  input ptr_t         wr_ptr,
  input ptr_t         rd_ptr,
  input logic         wr_primed,
  input logic         rd_primed,
  input logic [W-1:0] data_o
);
  // R8: write pointer steps by one and wraps
  a_r8_wr_ptr_step: assert property (@(posedge wclk_i) disable iff (!wr_rst_n)
    1'b1 |=> wr_ptr == $past(wr_ptr) + ptr_t'(1));

  // R8: read pointer steps by one and wraps
  a_r8_rd_ptr_step: assert property (@(posedge rclk_i) disable iff (!rd_rst_n)
    1'b1 |=> rd_ptr == $past(rd_ptr) + ptr_t'(1));

  // R6: non-zero output only after the synchronized fill indication
  a_r6_gate_out: assert property (@(posedge rclk_i) disable iff (!rd_rst_n)
    (data_o != '0) |-> $past(rd_primed));

  // R6: fill indication never drops outside reset
  a_r6_wr_primed_sticky: assert property (@(posedge wclk_i) disable iff (!wr_rst_n)
    wr_primed |=> wr_primed);

  a_r6_rd_primed_sticky: assert property (@(posedge rclk_i) disable iff (!rd_rst_n)
    rd_primed |=> rd_primed);
endmodule

bind meso_sync_fifo msf_checker #(.W(W)) u_chk (
  .wclk_i    (wclk_i),
  .rclk_i    (rclk_i),
  .wr_rst_n  (wr_rst_n),
  .rd_rst_n  (rd_rst_n),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .wr_primed (wr_primed),
  .rd_primed (rd_primed),
  .data_o    (data_o)
);

// File: tb/meso_sync_fifo_test.sv
`timescale 1ns/1ps
module meso_sync_fifo_test;
  localparam int W    = 10;
  localparam int HIST = 64;

  logic         wclk = 1'b0;
  logic         rclk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [W-1:0] data_o;

  real phase_ns = 0.0;
  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  // data generation state
  int  seq = 0;
  int  mode = 0;              // 0 random, 1 upper all ones, 2 alternating
  logic [W-1:0] hist [HIST];
  int  wr_cnt = 0;

  // read tracking
  bit  active = 1'b0;
  bit  locked = 1'b0;
  int  exp_idx = 0;
  int  rd_cycles = 0;
  int  gap0 = 0;

  meso_sync_fifo #(.W(W)) uut (
    .wclk_i (wclk), .rclk_i (rclk), .rst_ni (rst_ni),
    .data_i (data_i), .data_o (data_o)
  );

  always #2.5 wclk = ~wclk;
  always @(wclk) rclk <= #(phase_ns) wclk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // low bits carry a non-zero sequence tag so every word is non-zero and locally unique
  function automatic logic [W-1:0] make_word(input int s, input int m, input logic [W-1:0] r);
    logic [W-1:0] w;
    case (m)
      1:       w = '1;
      2:       w = (s % 2 == 0) ? {(W/2){2'b10}} : {(W/2){2'b01}};
      default: w = r;
    endcase
    w[5:0] = 6'((s % 63) + 1);
    return w;
  endfunction

  always @(negedge wclk) begin
    seq++;
    data_i <= make_word(seq, mode, W'($urandom));
  end

  always @(posedge wclk) begin
    if (rst_ni) begin
      hist[wr_cnt % HIST] = data_i;
      wr_cnt++;
    end
  end

  always @(posedge rclk) begin
    #1;
    if (active && rst_ni) begin
      rd_cycles++;
      if (!locked) begin
        if (data_o != '0) begin
          int k = -1;
          for (int j = wr_cnt - 1; j >= 0 && j >= wr_cnt - 8; j--)
            if (hist[j % HIST] == data_o && k < 0) k = j;
          check(k >= 0, "R4 first word found in input", int'(data_o), 0);
          // R6 bounded start
          check(rd_cycles >= 2 && rd_cycles <= 10, "R6 first word cycle", rd_cycles, 10);
          if (k >= 0) begin
            gap0 = wr_cnt - 1 - k;
            check(gap0 >= 1 && gap0 <= 4, "R4 latency gap", gap0, 2);
            exp_idx = k + 1;
          end
          locked = 1'b1;
        end else begin
          check(rd_cycles <= 10, "R6 output held zero too long", rd_cycles, 10);
        end
      end else begin
        // R2 R3 R4 R7: next word in order, no drop or repeat, constant gap
        check(data_o == hist[exp_idx % HIST], "R3 in-order word", int'(data_o),
              int'(hist[exp_idx % HIST]));
        check(wr_cnt - 1 - exp_idx == gap0, "R4 constant latency", wr_cnt - 1 - exp_idx, gap0);
        exp_idx++;
      end
    end
  end

  task automatic run_segment(input real ph, input int m, input int cycles);
    rst_ni = 1'b0;
    active = 1'b0;
    #0.4;
    check(data_o == '0, "R5 async reset clears output", int'(data_o), 0);
    phase_ns = ph;
    mode = m;
    repeat (4) @(negedge wclk);
    #0.3;
    check(data_o == '0, "R5 output zero in reset", int'(data_o), 0);
    locked = 1'b0;
    rd_cycles = 0;
    wr_cnt = 0;
    active = 1'b1;
    rst_ni = 1'b1;
    repeat (cycles) @(negedge wclk);
    check(locked, "R7 lock reached at phase", int'(ph * 10.0), 1);
  endtask

  initial begin
    #20000000;
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R7 phase sweep across one period, R1 full-width patterns
    run_segment(0.0, 0, 300);
    run_segment(0.7, 1, 200);
    run_segment(1.3, 2, 200);
    run_segment(2.5, 0, 300);
    run_segment(3.1, 1, 200);
    run_segment(3.9, 2, 200);
    run_segment(4.6, 0, 300);
    run_segment(4.95, 0, 300);
    // R5 mid-run asynchronous reset, off any edge
    #1.7;
    rst_ni = 1'b0;
    active = 1'b0;
    #0.2;
    check(data_o == '0, "R5 mid-run reset", int'(data_o), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule